// File: doc/BRIEF.md
# Flash ID Responder

This block answers the identification commands of a serial NOR flash. A command front end decodes the opcode, counts the serial bits received since chip select went low and captures the address byte. From those it works out which identification sequence the host wants, waits out the opcode and any dummy or address bytes, and shifts the identification bytes onto the serial data output. The sequence repeats for as long as chip select stays low.

Three commands are served. The JEDEC-style read returns a manufacturer byte followed by a two-byte device code. The electronic-signature read returns a single device byte after three dummy bytes. The manufacturer/device read returns a manufacturer byte and a device byte after two dummy bytes and an address byte, in an order set by bit 0 of that address byte. The electronic-signature opcode also wakes the part from deep power-down. While the part is powered down it is the only identification command served, and the block raises a one-cycle wake pulse for the power controller. All identification values are parameters.

The block runs on a system clock. The front end gives a one-cycle strobe for each serial-clock falling edge and a bit counter that steps on each rising edge, saturating at its maximum. The output pad buffer drives the serial data pin from `so_data` only while `so_oe` is high and leaves the pin floating otherwise.

Top module: `flash_id_responder`

## Requirements
- R1: Opcode 9Fh returns the bytes MFR_ID, JEDEC_DEV[15:8] and JEDEC_DEV[7:0], in that order. The first bit is shifted on the first falling strobe seen while the bit counter is at least 8. The three bytes repeat while chip select stays low.
- R2: Opcode ABh returns ES_ID from the first falling strobe seen while the bit counter is at least 32, repeated while chip select stays low.
- R3: Opcode 90h outputs from the first falling strobe seen while the bit counter is at least 32. If addr_byte[0] is 0 it returns MFR_ID then REMS_DEV; if it is 1 it returns REMS_DEV then MFR_ID. The pair repeats while chip select stays low. The other address bits are not used.
- R4: Each byte is shifted most significant bit first. so_data changes only in the clock cycle after a falling strobe that shifts a bit, so the host samples a stable bit at the next rising edge.
- R5: so_oe is low after reset, in the cycle after chip select is high, while no identification command is active, and before the first shifted bit. It rises only in the cycle after a falling strobe.
- R6: While in_dpd is high when the opcode is presented, opcodes 9Fh and 90h produce no output, and opcode ABh is served as in R2.
- R7: dpd_release pulses high for exactly one cycle, in the cycle after op_vld first goes high during a selection, when the opcode is ABh and in_dpd is high. It stays low in every other case.
- R8: Any opcode other than 9Fh, ABh and 90h leaves so_oe low for the whole selection.
- R9: Raising chip select in the middle of a byte abandons the sequence. The next selection starts again from the most significant bit of the first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low; high ends the command |
| sclk_fall | input | 1 | One-cycle strobe per serial-clock falling edge |
| bit_cnt | input | CNT_W | Bits received since selection, saturating |
| op_vld | input | 1 | Opcode byte is complete; held high until deselect |
| opcode | input | 8 | Decoded opcode byte, valid with op_vld |
| addr_byte | input | 8 | Captured address byte; bit 0 selects the order for 90h |
| in_dpd | input | 1 | Part is in deep power-down |
| so_data | output | 1 | Serial output data bit |
| so_oe | output | 1 | Output enable for the serial data pad |
| dpd_release | output | 1 | One-cycle wake request from deep power-down |

## Verification
The bound checker watches, on every cycle, that the wake pulse is one cycle wide and always follows an ABh opcode presented during power-down. It also watches that the output enable rises only after a falling strobe and drops after deselection, that it stays low with no active command, and that the data bit holds steady between shifts. Only the bench's scenarios can show that the byte values, their order, the repeat pattern, the address-selected order, the power-down filtering and the restart after an abandoned byte are right. For that it replays whole serial transactions and compares every byte it assembles against a queue of expected bytes.

// File: rtl/flash_id_pkg.sv
package flash_id_pkg;

  typedef enum logic [1:0] {
    ID_NONE  = 2'd0,
    ID_JEDEC = 2'd1,
    ID_ELEC  = 2'd2,
    ID_MFDEV = 2'd3
  } id_kind_e;

  localparam logic [7:0] OP_JEDEC = 8'h9F;
  localparam logic [7:0] OP_ELEC  = 8'hAB;
  localparam logic [7:0] OP_MFDEV = 8'h90;

  // Number of bits the host sends before the first output bit.
  localparam int unsigned LEAD_JEDEC = 8;
  localparam int unsigned LEAD_ELEC  = 32;
  localparam int unsigned LEAD_MFDEV = 32;

  // In power-down only the wake/signature opcode is served.
  function automatic id_kind_e decode_id_op(input logic [7:0] op, input logic dpd);
    id_kind_e k;
    case (op)
      OP_JEDEC: k = dpd ? ID_NONE : ID_JEDEC;
      OP_MFDEV: k = dpd ? ID_NONE : ID_MFDEV;
      OP_ELEC:  k = ID_ELEC;
      default:  k = ID_NONE;
    endcase
    return k;
  endfunction

  function automatic int unsigned lead_bits(input id_kind_e k);
    int unsigned n;
    case (k)
      ID_JEDEC: n = LEAD_JEDEC;
      ID_ELEC:  n = LEAD_ELEC;
      ID_MFDEV: n = LEAD_MFDEV;
      default:  n = 0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/flash_id_cmd_latch.sv
module flash_id_cmd_latch
  import flash_id_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       op_vld,
  input  logic [7:0] opcode,
  input  logic       in_dpd,
  output id_kind_e   kind,
  output logic       wake
);

  logic     seen_q, seen_d;
  id_kind_e kind_q, kind_d;
  logic     wake_q, wake_d;

  always_comb begin
    seen_d = seen_q;
    kind_d = kind_q;
    wake_d = 1'b0;
    if (cs_n) begin
      seen_d = 1'b0;
      kind_d = ID_NONE;
    end else if (op_vld && !seen_q) begin
      seen_d = 1'b1;
      kind_d = decode_id_op(opcode, in_dpd);
      wake_d = (opcode == OP_ELEC) && in_dpd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      kind_q <= ID_NONE;
      wake_q <= 1'b0;
    end else begin
      seen_q <= seen_d;
      kind_q <= kind_d;
      wake_q <= wake_d;
    end
  end

  assign kind = kind_q;
  assign wake = wake_q;

endmodule

// File: rtl/flash_id_seq_ctr.sv
module flash_id_seq_ctr #(
  parameter int MAX_BYTES = 3,
  localparam int BYTE_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  logic [BYTE_W-1:0] last_byte,
  output logic [2:0]        bit_idx,
  output logic [BYTE_W-1:0] byte_idx
);

  logic [2:0]        bit_q, bit_d;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic              cnt_en;

  assign cnt_en = clr | adv;

  always_comb begin
    bit_d  = bit_q;
    byte_d = byte_q;
    if (clr) begin
      bit_d  = '0;
      byte_d = '0;
    end else if (adv) begin
      bit_d = bit_q + 3'd1;
      if (bit_q == 3'd7) begin
        byte_d = (byte_q >= last_byte) ? '0 : byte_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= '0;
      byte_q <= '0;
    end else if (cnt_en) begin
      bit_q  <= bit_d;
      byte_q <= byte_d;
    end
  end

  assign bit_idx  = bit_q;
  assign byte_idx = byte_q;

endmodule

// File: rtl/flash_id_byte_sel.sv
module flash_id_byte_sel
  import flash_id_pkg::*;
#(
  parameter logic [7:0]  MFR_ID    = 8'hA5,
  parameter logic [15:0] JEDEC_DEV = 16'h3C17,
  parameter logic [7:0]  ES_ID     = 8'h5E,
  parameter logic [7:0]  REMS_DEV  = 8'h6B,
  parameter int          BYTE_W    = 2
) (
  input  id_kind_e          kind,
  input  logic [BYTE_W-1:0] byte_idx,
  input  logic              dev_first,
  output logic [7:0]        id_byte,
  output logic [BYTE_W-1:0] last_byte
);

  localparam int SEQ_LEN = 3;

  logic [7:0] seq [SEQ_LEN];

  // Sequence slots for the active command; unused slots read as zero.
  always_comb begin
    for (int s = 0; s < SEQ_LEN; s++) seq[s] = 8'h00;
    last_byte = '0;
    case (kind)
      ID_JEDEC: begin
        seq[0]    = MFR_ID;
        seq[1]    = JEDEC_DEV[15:8];
        seq[2]    = JEDEC_DEV[7:0];
        last_byte = BYTE_W'(2);
      end
      ID_ELEC: begin
        seq[0] = ES_ID;
      end
      ID_MFDEV: begin
        seq[0]    = dev_first ? REMS_DEV : MFR_ID;
        seq[1]    = dev_first ? MFR_ID : REMS_DEV;
        last_byte = BYTE_W'(1);
      end
      default: ;
    endcase
  end

  always_comb begin
    id_byte = 8'h00;
    for (int s = 0; s < SEQ_LEN; s++) begin
      if (int'(byte_idx) == s) id_byte = seq[s];
    end
  end

endmodule

// File: rtl/flash_id_responder.sv
module flash_id_responder
  import flash_id_pkg::*;
#(
  parameter int          CNT_W     = 6,
  parameter logic [7:0]  MFR_ID    = 8'hA5,
  parameter logic [15:0] JEDEC_DEV = 16'h3C17,
  parameter logic [7:0]  ES_ID     = 8'h5E,
  parameter logic [7:0]  REMS_DEV  = 8'h6B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk_fall,
  input  logic [CNT_W-1:0] bit_cnt,
  input  logic             op_vld,
  input  logic [7:0]       opcode,
  input  logic [7:0]       addr_byte,
  input  logic             in_dpd,
  output logic             so_data,
  output logic             so_oe,
  output logic             dpd_release
);

  localparam int MAX_BYTES = 3;
  localparam int BYTE_W    = $clog2(MAX_BYTES);

  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  id_kind_e          cmd_kind;
  logic [2:0]        bit_idx;
  logic [BYTE_W-1:0] byte_idx;
  logic [BYTE_W-1:0] last_byte;
  logic [7:0]        id_byte;
  logic              lead_done;
  logic              shift_now;

  flash_id_cmd_latch u_cmd (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .cs_n   (cs_n),
    .op_vld (op_vld),
    .opcode (opcode),
    .in_dpd (in_dpd),
    .kind   (cmd_kind),
    .wake   (dpd_release)
  );

  flash_id_byte_sel #(
    .MFR_ID    (MFR_ID),
    .JEDEC_DEV (JEDEC_DEV),
    .ES_ID     (ES_ID),
    .REMS_DEV  (REMS_DEV),
    .BYTE_W    (BYTE_W)
  ) u_sel (
    .kind      (cmd_kind),
    .byte_idx  (byte_idx),
    .dev_first (addr_byte[0]),
    .id_byte   (id_byte),
    .last_byte (last_byte)
  );

  flash_id_seq_ctr #(
    .MAX_BYTES (MAX_BYTES)
  ) u_ctr (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .clr       (cs_n),
    .adv       (shift_now),
    .last_byte (last_byte),
    .bit_idx   (bit_idx),
    .byte_idx  (byte_idx)
  );

  assign lead_done = (32'(bit_cnt) >= lead_bits(cmd_kind));
  assign shift_now = !cs_n && sclk_fall && (cmd_kind != ID_NONE) && lead_done;

  logic so_q, so_d, oe_q, oe_d, out_en;

  assign out_en = shift_now | cs_n;

  always_comb begin
    so_d = so_q;
    oe_d = oe_q;
    if (cs_n) begin
      oe_d = 1'b0;
    end else if (shift_now) begin
      so_d = id_byte[3'd7 - bit_idx];
      oe_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      so_q <= 1'b0;
      oe_q <= 1'b0;
    end else if (out_en) begin
      so_q <= so_d;
      oe_q <= oe_d;
    end
  end

  assign so_data = so_q;
  assign so_oe   = oe_q;

endmodule

// File: rtl/flash_id_responder_chk.sv
module flash_id_responder_chk
  import flash_id_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sclk_fall,
  input logic       op_vld,
  input logic [7:0] opcode,
  input logic       in_dpd,
  input logic       so_data,
  input logic       so_oe,
  input logic       dpd_release,
  input id_kind_e   cmd_kind
);

  // R7: wake pulse lasts one cycle
  p_wake_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dpd_release |=> !dpd_release);

  // R7: wake pulse only after the signature opcode in power-down
  p_wake_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dpd_release |-> $past(op_vld && (opcode == OP_ELEC) && in_dpd && !cs_n));

  // R5: output enable rises only after a falling strobe
  p_oe_after_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(so_oe) |-> $past(sclk_fall));

  // R5: pin floats after deselection
  p_hiz_deselect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> !so_oe);

  // R4: data bit holds between shifts
  p_data_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (so_oe && $past(so_oe) && !$past(sclk_fall)) |-> $stable(so_data));

  // R8: no active command, no drive
  p_no_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_kind == ID_NONE) |-> !so_oe);

endmodule

bind flash_id_responder flash_id_responder_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_n        (cs_n),
  .sclk_fall   (sclk_fall),
  .op_vld      (op_vld),
  .opcode      (opcode),
  .in_dpd      (in_dpd),
  .so_data     (so_data),
  .so_oe       (so_oe),
  .dpd_release (dpd_release),
  .cmd_kind    (cmd_kind)
);

// File: tb/test_flash_id_responder.sv
module test_flash_id_responder;

  localparam int          CNT_W = 6;
  localparam logic [7:0]  MFR   = 8'hA5;
  localparam logic [15:0] JDEV  = 16'h3C17;
  localparam logic [7:0]  ES    = 8'h5E;
  localparam logic [7:0]  RDEV  = 8'h6B;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cs_n;
  logic             sclk_fall;
  logic [CNT_W-1:0] bit_cnt;
  logic             op_vld;
  logic [7:0]       opcode;
  logic [7:0]       addr_byte;
  logic             in_dpd;
  logic             so_data;
  logic             so_oe;
  logic             dpd_release;
  logic             rise_evt;

  always #2.5 clk = ~clk;

  flash_id_responder #(
    .CNT_W(CNT_W), .MFR_ID(MFR), .JEDEC_DEV(JDEV), .ES_ID(ES), .REMS_DEV(RDEV)
  ) i_flash_id_responder (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk_fall(sclk_fall),
    .bit_cnt(bit_cnt), .op_vld(op_vld), .opcode(opcode),
    .addr_byte(addr_byte), .in_dpd(in_dpd), .so_data(so_data),
    .so_oe(so_oe), .dpd_release(dpd_release)
  );

  int    checks = 0;
  int    failures = 0;
  int    wake_cnt = 0;
  bit    done = 1'b0;
  string cur_req = "R0";
  logic [7:0] exp_q[$];

  // Monitor: assembles bytes at each host sampling edge and scores them.
  initial begin
    logic [7:0] sh;
    int         nb;
    logic [7:0] e;
    nb = 0;
    sh = '0;
    forever begin
      @(posedge clk);
      #1;
      if (dpd_release) wake_cnt++;
      if (cs_n) begin
        nb = 0;
      end else if (rise_evt && so_oe) begin
        sh = {sh[6:0], so_data};
        nb++;
        if (nb == 8) begin
          nb = 0;
          checks++;
          if (exp_q.size() == 0) begin
            failures++;
            $display("FAIL %s: unexpected byte %h, expected none", cur_req, sh);
          end else begin
            e = exp_q.pop_front();
            if (sh !== e) begin
              failures++;
              $display("FAIL %s: byte %h expected %h", cur_req, sh, e);
            end
          end
        end
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // One selection: out_bits bit periods after the lead-in of lead bits.
  task automatic run_cmd(input logic [7:0] op, input logic [7:0] addr, input logic dpd,
                         input int lead, input int out_bits, input int exp_wake);
    int total;
    total = lead + out_bits;
    wake_cnt = 0;
    @(negedge clk);
    in_dpd = dpd;
    addr_byte = addr;
    cs_n = 1'b0;
    for (int i = 0; i < total; i++) begin
      @(negedge clk);
      bit_cnt = (i + 1 > 63) ? CNT_W'(63) : CNT_W'(i + 1);
      rise_evt = 1'b1;
      if (i + 1 == 8) begin
        op_vld = 1'b1;
        opcode = op;
      end
      @(negedge clk);
      rise_evt = 1'b0;
      @(negedge clk);
      sclk_fall = 1'b1;
      @(negedge clk);
      sclk_fall = 1'b0;
    end
    @(negedge clk);
    cs_n = 1'b1;
    op_vld = 1'b0;
    bit_cnt = '0;
    repeat (3) @(negedge clk);
    check({cur_req, " leftover expected bytes"}, exp_q.size(), 0);
    exp_q.delete();
    check({cur_req, " R7 wake pulses"}, wake_cnt, exp_wake);
    check({cur_req, " R5 so_oe after deselect"}, so_oe, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    cs_n = 1'b1;
    sclk_fall = 1'b0;
    bit_cnt = '0;
    op_vld = 1'b0;
    opcode = '0;
    addr_byte = '0;
    in_dpd = 1'b0;
    rise_evt = 1'b0;
    repeat (4) @(negedge clk);
    check("R5 reset so_oe", so_oe, 0);
    check("R7 reset dpd_release", dpd_release, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    cur_req = "R1 R4 jedec repeat";
    exp_q = '{MFR, JDEV[15:8], JDEV[7:0], MFR, JDEV[15:8], JDEV[7:0], MFR};
    run_cmd(8'h9F, 8'h00, 1'b0, 8, 56, 0);

    cur_req = "R3 addr bit0=0";
    exp_q = '{MFR, RDEV, MFR, RDEV};
    run_cmd(8'h90, 8'h00, 1'b0, 32, 32, 0);

    cur_req = "R3 addr bit0=1";
    exp_q = '{RDEV, MFR, RDEV};
    run_cmd(8'h90, 8'h01, 1'b0, 32, 24, 0);

    cur_req = "R3 addr FEh uses bit0";
    exp_q = '{MFR, RDEV};
    run_cmd(8'h90, 8'hFE, 1'b0, 32, 16, 0);

    cur_req = "R2 signature awake";
    exp_q = '{ES, ES, ES};
    run_cmd(8'hAB, 8'h00, 1'b0, 32, 24, 0);

    cur_req = "R6 jedec in power-down";
    run_cmd(8'h9F, 8'h00, 1'b1, 8, 24, 0);

    cur_req = "R6 mfr/dev in power-down";
    run_cmd(8'h90, 8'h00, 1'b1, 32, 16, 0);

    cur_req = "R6 R7 signature in power-down";
    exp_q = '{ES, ES};
    run_cmd(8'hAB, 8'h00, 1'b1, 32, 16, 1);

    cur_req = "R8 unrelated opcode";
    run_cmd(8'h03, 8'h00, 1'b0, 8, 32, 0);

    cur_req = "R9 abandoned byte";
    exp_q = '{MFR};
    run_cmd(8'h9F, 8'h00, 1'b0, 8, 12, 0);

    cur_req = "R9 restart from first byte";
    exp_q = '{MFR, JDEV[15:8]};
    run_cmd(8'h9F, 8'h00, 1'b0, 8, 16, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int k = 0; k < 100000 && !done; k++) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule